// File: doc/BRIEF.md
# Tree-Structured Mismatch-Shaping Encoder

This block drives a unit-element DAC of eight equal cells from a small code that says how many of them should be on. Several cell patterns give the same count, and the block uses that freedom to choose among them. It splits the code through a binary tree of switching blocks. The top block divides the whole count between two halves of the array. Each half is divided again, until every leaf block enables at most one cell on each side. Because of this, any cell mismatch appears at the output as first-order high-pass shaped noise and not as distortion.

Each switching block divides an even input evenly. It gives the extra unit of an odd input to one side. The side alternates from one odd input to the next at that block, even when even inputs come in between. This alternation is the block's ternary shaping sequence, whose nonzero values alternate in sign. After a reset each block forgets its history. The side for its first odd split comes from one bit of a shared free-running LFSR, and every block uses a different bit, so the blocks start out decorrelated. Codes above the number of cells are clipped to full scale. The enables are registered, so they appear one clock after the code is sampled.

Top module: `tms_encoder`

## Requirements
- R1: While reset is low at a rising edge, every enable is 0 after that edge, whatever the code.
- R2: One clock after a code is sampled, the number of enables set equals min(code, 8).
- R3: A code from 9 to 15 turns on all eight enables (0xFF).
- R4: For each switching block, the input is the sum of the enables below it. If that input is even, the two halves get equal counts. Halves are taken with the lower-index cells as the first output.
- R5: For each switching block with an odd input, the two half counts differ by exactly one.
- R6: For each switching block, successive odd inputs since reset give the extra unit to opposite halves. This holds across any number of even inputs in between.
- R7: A block in layer k (layer 3 is the top, layer 1 drives the cell pairs) never gives either half more than 2^(k-1).
- R8: Over any eight consecutive samples of code 1, each of the eight enables is set exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code | input | 4 | Number of cells to enable (0 to 8; larger values clip to 8) |
| en | output | 8 | Registered cell enables; bit i drives cell i |

## Verification
Every result is due exactly one rising edge after the code is presented. That covers the enable count, the half balances of every block and the alternation of each block's odd splits. The reset clear also appears one edge after reset is seen low. The bench changes the code on the falling edge. It samples the enables on the next falling edge, half a period after the edge that registered them, and checks each sample against that one code. It rebuilds every block's input and split from the enable pattern alone. It keeps its own record of each block's last odd direction and forgets it whenever reset is applied.

// File: rtl/tms_pkg.sv
package tms_pkg;
   localparam int unsigned LFSR_W = 16;
   localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
   localparam int unsigned MAX_LAYERS = 4;
endpackage

// File: rtl/tms_lfsr.sv
module tms_lfsr #(
   parameter int unsigned W     = 16,
   parameter logic [W-1:0] SEED = 16'hACE1,
   parameter int unsigned OUT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] tap
);
   logic [W-1:0] state_q;
   logic         fb;

   generate
      if (OUT_W > W) begin : g_bad_out
         $error("tms_lfsr: OUT_W exceeds register width");
      end
      if (W == 16) begin : g_w16
         assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
      end else if (W == 8) begin : g_w8
         assign fb = state_q[7] ^ state_q[5] ^ state_q[4] ^ state_q[3];
      end else begin : g_bad_w
         $error("tms_lfsr: unsupported width");
         assign fb = state_q[W-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= {state_q[W-2:0], fb};
   end

   assign tap = state_q[OUT_W-1:0];
endmodule

// File: rtl/tms_split.sv
module tms_split #(
   parameter int unsigned LAYER = 1,
   parameter int unsigned VW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          seed,
   input  logic [VW-1:0] x,
   output logic [VW-1:0] lo,
   output logic [VW-1:0] hi
);
   generate
      if (LAYER < 1 || VW < LAYER + 1) begin : g_bad
         $error("tms_split: value width too small for layer");
      end
   endgenerate

   logic          fresh_q;
   logic          pos_q;
   logic          odd;
   logic          want_pos;
   logic [VW-1:0] base;

   always_comb begin
      odd      = x[0];
      base     = x >> 1;
      want_pos = fresh_q ? seed : ~pos_q;
      lo       = base + VW'(odd & want_pos);
      hi       = base + VW'(odd & ~want_pos);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fresh_q <= 1'b1;
         pos_q   <= 1'b0;
      end else if (odd) begin
         fresh_q <= 1'b0;
         pos_q   <= want_pos;
      end
   end
endmodule

// File: rtl/tms_tree.sv
module tms_tree #(
   parameter int unsigned LAYERS = 3,
   parameter int unsigned VW     = LAYERS + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [VW-1:0]            root,
   input  logic [(1<<LAYERS)-2:0]   seed,
   output logic [(1<<LAYERS)-1:0]   leaves
);
   localparam int unsigned ELEM  = 1 << LAYERS;
   localparam int unsigned NODES = 2 * ELEM;

   logic [VW-1:0] val [1:NODES-1];

   assign val[1] = root;

   generate
      for (genvar d = 0; d < LAYERS; d++) begin : g_lvl
         for (genvar j = 0; j < (1 << d); j++) begin : g_blk
            localparam int unsigned I = (1 << d) + j;
            tms_split #(.LAYER(LAYERS - d), .VW(VW)) u_sw (
               .clk  (clk),
               .rst_n(rst_n),
               .seed (seed[I-1]),
               .x    (val[I]),
               .lo   (val[2*I]),
               .hi   (val[2*I+1])
            );
         end
      end
      for (genvar e = 0; e < ELEM; e++) begin : g_leaf
         assign leaves[e] = (val[ELEM+e] != '0);
      end
   endgenerate
endmodule

// File: rtl/tms_encoder.sv
module tms_encoder #(
   parameter int unsigned LAYERS = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LAYERS:0]        code,
   output logic [(1<<LAYERS)-1:0] en
);
   import tms_pkg::*;

   localparam int unsigned ELEM = 1 << LAYERS;
   localparam int unsigned CW   = LAYERS + 1;
   localparam int unsigned NBLK = ELEM - 1;

   generate
      if (LAYERS < 1 || LAYERS > MAX_LAYERS) begin : g_bad_layers
         $error("tms_encoder: LAYERS out of supported range");
      end
      if (NBLK > LFSR_W) begin : g_bad_seed
         $error("tms_encoder: not enough LFSR bits for all blocks");
      end
   endgenerate

   logic [CW-1:0]   root;
   logic [NBLK-1:0] seeds;
   logic [ELEM-1:0] leaves;

   assign root = (code > CW'(ELEM)) ? CW'(ELEM) : code;

   tms_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .OUT_W(NBLK)) u_lfsr (
      .clk  (clk),
      .rst_n(rst_n),
      .tap  (seeds)
   );

   tms_tree #(.LAYERS(LAYERS), .VW(CW)) u_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .root  (root),
      .seed  (seeds),
      .leaves(leaves)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) en <= '0;
      else        en <= leaves;
   end
endmodule

// File: rtl/tms_encoder_chk.sv
module tms_encoder_chk #(
   parameter int unsigned LAYERS = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [LAYERS:0]        code,
   input logic [(1<<LAYERS)-1:0] en
);
   localparam int unsigned ELEM = 1 << LAYERS;
   localparam int unsigned HE   = ELEM / 2;
   localparam int unsigned CW   = LAYERS + 1;

   logic [CW-1:0] want;
   int            lo_cnt;
   int            hi_cnt;
   logic          seen_q;
   logic          last_lo_q;

   assign want   = (code > CW'(ELEM)) ? CW'(ELEM) : code;
   assign lo_cnt = $countones(en[HE-1:0]);
   assign hi_cnt = $countones(en[ELEM-1:HE]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         last_lo_q <= 1'b0;
      end else if (lo_cnt != hi_cnt) begin
         seen_q    <= 1'b1;
         last_lo_q <= (lo_cnt > hi_cnt);
      end
   end

   AST_ONES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($countones(en) == int'($past(want)))); // R2
   AST_CLIP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(code) > CW'(ELEM)) |-> (en == '1)); // R3
   AST_EVEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(want[0])) |-> (lo_cnt == hi_cnt)); // R4
   AST_ODD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(want[0])) |-> (lo_cnt == hi_cnt + 1 || hi_cnt == lo_cnt + 1)); // R5
   AST_TOP_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && lo_cnt != hi_cnt) |-> ((lo_cnt > hi_cnt) != last_lo_q)); // R6
endmodule

bind tms_encoder tms_encoder_chk #(.LAYERS(LAYERS)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .code (code),
   .en   (en)
);

// File: tb/tms_encoder_test.sv
module tms_encoder_test;
   localparam int L = 3;
   localparam int E = 1 << L;

   logic         clk;
   logic         rst_n;
   logic [L:0]   code;
   logic [E-1:0] en;

   int checks;
   int errors;
   int last_dir [1:E-1];
   bit known    [1:E-1];
   bit done;

   tms_encoder #(.LAYERS(L)) uut (.clk(clk), .rst_n(rst_n), .code(code), .en(en));

   initial clk = 1'b0;
   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic forget();
      for (int i = 1; i < E; i++) begin
         known[i]    = 1'b0;
         last_dir[i] = 0;
      end
   endtask

   task automatic evaluate(input int c);
      int val [1:2*E-1];
      int sat;
      sat = (c > E) ? E : c;
      for (int e = 0; e < E; e++) val[E+e] = int'(en[e]);
      for (int i = E - 1; i >= 1; i--) val[i] = val[2*i] + val[2*i+1];
      check(val[1] == sat, "R2", val[1], sat);
      if (c > E) check(en == '1, "R3", int'(en), 255);
      for (int i = 1; i < E; i++) begin
         int d;
         int half;
         int diff;
         d = $clog2(i + 1) - 1;
         half = 1 << (L - d - 1);
         check(val[2*i] <= half && val[2*i+1] <= half, "R7",
               (val[2*i] > val[2*i+1]) ? val[2*i] : val[2*i+1], half);
         diff = val[2*i] - val[2*i+1];
         if (val[i] % 2 == 0) begin
            check(diff == 0, "R4", diff, 0);
         end else begin
            check(diff == 1 || diff == -1, "R5", diff, 1);
            if (known[i]) check(diff != last_dir[i], "R6", diff, -last_dir[i]);
            last_dir[i] = diff;
            known[i]    = 1'b1;
         end
      end
   endtask

   task automatic step(input int c);
      code = c[L:0];
      @(posedge clk);
      @(negedge clk);
      evaluate(c);
   endtask

   task automatic do_reset(input int c);
      code  = c[L:0];
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(en == '0, "R1", int'(en), 0);
      @(posedge clk);
      @(negedge clk);
      check(en == '0, "R1", int'(en), 0);
      forget();
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int lcg;
      checks = 0;
      errors = 0;
      done   = 1'b0;
      forget();
      rst_n = 1'b0;
      code  = '0;
      @(negedge clk);
      do_reset(5);

      // sweep every code, several repeats each (R2-R7)
      for (int c = 0; c < 16; c++)
         for (int r = 0; r < 4; r++) step(c);

      // R8: constant code 1 visits every cell once in eight samples
      for (int w = 0; w < 3; w++) begin
         int hits [E];
         for (int e = 0; e < E; e++) hits[e] = 0;
         for (int t = 0; t < E; t++) begin
            step(1);
            for (int e = 0; e < E; e++) hits[e] += int'(en[e]);
         end
         for (int e = 0; e < E; e++) check(hits[e] == 1, "R8", hits[e], 1);
      end

      // odd codes separated by even ones (R6 across gaps)
      for (int r = 0; r < 12; r++) begin
         step(3);
         step(2);
         step(0);
         step(5);
         step(8);
         step(7);
      end

      // reset in mid-run clears history (R1)
      do_reset(7);

      // ramps up and down
      for (int r = 0; r < 3; r++) begin
         for (int c = 0; c <= E; c++) step(c);
         for (int c = E; c >= 0; c--) step(c);
      end

      // pseudo-random codes, mostly in range
      lcg = 12345;
      for (int t = 0; t < 600; t++) begin
         lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
         step((lcg >> 16) % 11);
      end

      do_reset(9);
      for (int c = 15; c >= 0; c--) step(c);

      finish_run();
   end
endmodule